// File: doc/BRIEF.md
# Software Reset Control Unit

This block keeps the reset-control registers of a protected configuration bank and turns them into reset outputs. Software writes through a plain register write port. Each write arrives already qualified, meaning the bank was unlocked when the write was issued. Three word addresses are decoded:

- **System reset request word.** Setting bit 0 produces a one-cycle request to reset the whole system.
- **Processor reset word.** Its low bits hold each processor in reset.
- **Logic reset word.** This is a sparse control word. Only its valid bits are kept. Those bits are compacted into a dense vector of reset lines, and the lowest four lines are inverted on the way.

The soft-reset request comes from a small two-state machine. In state `SR_IDLE` the request output is low. In state `SR_PULSE` it is high. The transitions are:

- `SR_IDLE -> SR_PULSE` on an accepted request write.
- `SR_PULSE -> SR_PULSE` when another request write arrives in the same cycle.
- `SR_PULSE -> SR_IDLE` in every other case.

Every output is registered, so each output changes in the first cycle after the write that affects it.

Top module: `soft_reset_ctrl`

## Requirements
- R1: While reset is asserted and after it is released, `sys_reset_req_o` is 0 and `cpu_reset_o` is 0. `pl_reset_o` equals 17'h1FFF0: lines 0..3 are low and lines 4..16 are high, because the stored logic reset word resets to 0x01F33F0F.
- R2: A write to byte offset 0x200 with bit 0 set raises `sys_reset_req_o` for exactly the following cycle. Writes of that kind in consecutive cycles give one high cycle each, and the high cycles are contiguous.
- R3: A write to offset 0x200 with bit 0 clear raises no request. The other bits of that word have no effect on any output.
- R4: After a write to offset 0x244, bit i of the written data appears on `cpu_reset_o[i]` for i = 0 and 1, with 1 meaning held in reset. Higher data bits are ignored.
- R5: A write to offset 0x240 is ANDed with the valid mask 0x01F33F0F before it is stored. Bits outside the mask have no effect on `pl_reset_o`.
- R6: Stored bits 0..3 drive output lines 0..3 inverted. All other valid bits drive their lines unchanged.
- R7: Output lines are assigned to valid mask bits in ascending bit order. Lines 0..3 come from bits 0..3, lines 4..9 from bits 8..13, lines 10..11 from bits 16..17, and lines 12..16 from bits 20..24.
- R8: No output changes when `wr_en_i` is low, or when the write address is not one of 0x200, 0x240 or 0x244. A write to one of those three words leaves the outputs owned by the other two unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous active-low reset |
| wr_en_i | input | 1 | Qualified write strobe (bank already unlocked) |
| wr_addr_i | input | 12 | Byte address of the write; bits 1:0 are ignored |
| wr_data_i | input | 32 | Write data |
| sys_reset_req_o | output | 1 | One-cycle whole-system reset request |
| cpu_reset_o | output | 2 | Per-processor reset lines, 1 = held in reset |
| pl_reset_o | output | 17 | Compacted logic reset lines |

## Verification
The embedded assertions check, on every cycle, that a request pulse only follows a request write and that no request appears without one. They also check that processor and logic lines hold still when their word is not written, that a processor write lands on the lines one cycle later, and that the inverted low four lines follow the written data. The full bit-to-line compaction order, the discarding of bits outside the mask, and the reset value are shown only by the bench's directed scenarios. The same applies to back-to-back request pulses and the ignoring of foreign addresses. In those scenarios the bench walks a single bit through every position of the logic reset word.

// File: rtl/srcu_pkg.sv
package srcu_pkg;
    parameter int unsigned SRCU_ADDR_W = 12;
    parameter int unsigned SRCU_DATA_W = 32;

    localparam logic [SRCU_ADDR_W-1:0] OFS_SYS = 12'h200;
    localparam logic [SRCU_ADDR_W-1:0] OFS_PL  = 12'h240;
    localparam logic [SRCU_ADDR_W-1:0] OFS_CPU = 12'h244;

    typedef enum logic [0:0] {
        SR_IDLE  = 1'b0,
        SR_PULSE = 1'b1
    } sr_state_e;

    function automatic int count_ones(input logic [63:0] v);
        int n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (v[i]) n++;
        end
        return n;
    endfunction

    function automatic int count_below(input logic [63:0] v, input int pos);
        int n;
        n = 0;
        for (int i = 0; i < 64; i++) begin
            if (i < pos && v[i]) n++;
        end
        return n;
    endfunction

    function automatic logic [63:0] pack_bits(input logic [63:0] mask,
                                              input logic [63:0] word);
        logic [63:0] r;
        int k;
        r = '0;
        k = 0;
        for (int i = 0; i < 64; i++) begin
            if (mask[i]) begin
                r[k] = word[i];
                k++;
            end
        end
        return r;
    endfunction
endpackage

// File: rtl/srcu_pulse_fsm.sv
module srcu_pulse_fsm
    import srcu_pkg::*;
(
    input  logic clk_i,
    input  logic rst_ni,
    input  logic req_i,
    output logic pulse_o
);
    sr_state_e state_q, state_d;

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            SR_IDLE:  state_d = req_i ? SR_PULSE : SR_IDLE;
            SR_PULSE: state_d = req_i ? SR_PULSE : SR_IDLE;
            default:  state_d = SR_IDLE;
        endcase
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) state_q <= SR_IDLE;
        else         state_q <= state_d;
    end

    always_comb begin
        unique case (state_q)
            SR_PULSE: pulse_o = 1'b1;
            default:  pulse_o = 1'b0;
        endcase
    end

    assert_pulse_cause_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        req_i |=> pulse_o);
    assert_no_spurious_R3: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !req_i |=> !pulse_o);
endmodule

// File: rtl/srcu_cpu_reg.sv
module srcu_cpu_reg #(
    parameter int unsigned DATA_W = 32,
    parameter int unsigned N_CPU  = 2
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [N_CPU-1:0]  cpu_reset_o
);
    logic [N_CPU-1:0] hold_q;
    logic             unused_hi;

    assign unused_hi = ^wdata_i[DATA_W-1:N_CPU];

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   hold_q <= '0;
        else if (we_i) hold_q <= wdata_i[N_CPU-1:0];
    end

    assign cpu_reset_o = hold_q;

    assert_cpu_load_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
        we_i |=> cpu_reset_o == $past(wdata_i[N_CPU-1:0]));
    assert_cpu_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(cpu_reset_o));
endmodule

// File: rtl/srcu_pl_bank.sv
module srcu_pl_bank
    import srcu_pkg::*;
#(
    parameter int unsigned       DATA_W = 32,
    parameter logic [DATA_W-1:0] VALID  = 32'h01F3_3F0F,
    parameter logic [DATA_W-1:0] INVERT = 32'h0000_000F,
    parameter int unsigned       PL_N   = 17
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              we_i,
    input  logic [DATA_W-1:0] wdata_i,
    output logic [PL_N-1:0]   pl_reset_o
);
    localparam logic [63:0] RST_WIDE =
        pack_bits(64'(VALID), 64'(VALID ^ (INVERT & VALID)));
    localparam logic [PL_N-1:0] RST_LINES = RST_WIDE[PL_N-1:0];

    logic [PL_N-1:0] lines_d;
    logic [PL_N-1:0] lines_q;
    logic            unused_invalid;

    assign unused_invalid = ^(wdata_i & ~VALID);

    for (genvar b = 0; b < DATA_W; b++) begin : g_bit
        if (VALID[b]) begin : g_valid
            localparam int LINE = count_below(64'(VALID), b);
            assign lines_d[LINE] = wdata_i[b] ^ INVERT[b];
        end
    end

    always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni)   lines_q <= RST_LINES;
        else if (we_i) lines_q <= lines_d;
    end

    assign pl_reset_o = lines_q;

    assert_pl_hold_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        !we_i |=> $stable(pl_reset_o));

    if (VALID[3:0] == 4'hF && INVERT[3:0] == 4'hF) begin : g_inv_chk
        assert_pl_invert_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
            we_i |=> pl_reset_o[3:0] == ~$past(wdata_i[3:0]));
    end
endmodule

// File: rtl/soft_reset_ctrl.sv
module soft_reset_ctrl
    import srcu_pkg::*;
#(
    parameter int unsigned       ADDR_W    = SRCU_ADDR_W,
    parameter int unsigned       DATA_W    = SRCU_DATA_W,
    parameter int unsigned       N_CPU     = 2,
    parameter logic [DATA_W-1:0] PL_VALID  = 32'h01F3_3F0F,
    parameter logic [DATA_W-1:0] PL_INVERT = 32'h0000_000F,
    localparam int unsigned      PL_N      = count_ones(64'(PL_VALID))
) (
    input  logic              clk_i,
    input  logic              rst_ni,
    input  logic              wr_en_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [DATA_W-1:0] wr_data_i,
    output logic              sys_reset_req_o,
    output logic [N_CPU-1:0]  cpu_reset_o,
    output logic [PL_N-1:0]   pl_reset_o
);
    logic hit_sys, hit_pl, hit_cpu, sys_req;
    logic unused_lsb;

    assign unused_lsb = ^wr_addr_i[1:0];
    assign hit_sys = wr_en_i && (wr_addr_i[ADDR_W-1:2] == OFS_SYS[ADDR_W-1:2]);
    assign hit_pl  = wr_en_i && (wr_addr_i[ADDR_W-1:2] == OFS_PL[ADDR_W-1:2]);
    assign hit_cpu = wr_en_i && (wr_addr_i[ADDR_W-1:2] == OFS_CPU[ADDR_W-1:2]);
    assign sys_req = hit_sys && wr_data_i[0];

    srcu_pulse_fsm u_pulse (
        .clk_i   (clk_i),
        .rst_ni  (rst_ni),
        .req_i   (sys_req),
        .pulse_o (sys_reset_req_o)
    );

    srcu_cpu_reg #(.DATA_W(DATA_W), .N_CPU(N_CPU)) u_cpu (
        .clk_i       (clk_i),
        .rst_ni      (rst_ni),
        .we_i        (hit_cpu),
        .wdata_i     (wr_data_i),
        .cpu_reset_o (cpu_reset_o)
    );

    srcu_pl_bank #(.DATA_W(DATA_W), .VALID(PL_VALID), .INVERT(PL_INVERT),
                   .PL_N(PL_N)) u_pl (
        .clk_i      (clk_i),
        .rst_ni     (rst_ni),
        .we_i       (hit_pl),
        .wdata_i    (wr_data_i),
        .pl_reset_o (pl_reset_o)
    );

    assert_req_onehot_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $onehot0({hit_sys, hit_pl, hit_cpu}));
endmodule

// File: tb/soft_reset_ctrl_tb_top.sv
`timescale 1ns/1ps
module soft_reset_ctrl_tb_top;
    localparam logic [31:0] MASK = 32'h01F3_3F0F;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        wr_en = 1'b0;
    logic [11:0] wr_addr = '0;
    logic [31:0] wr_data = '0;
    logic        sys_req;
    logic [1:0]  cpu_rst;
    logic [16:0] pl_rst;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    always #2.5 clk = ~clk;

    soft_reset_ctrl dut_i (
        .clk_i           (clk),
        .rst_ni          (rst_n),
        .wr_en_i         (wr_en),
        .wr_addr_i       (wr_addr),
        .wr_data_i       (wr_data),
        .sys_reset_req_o (sys_req),
        .cpu_reset_o     (cpu_rst),
        .pl_reset_o      (pl_rst)
    );

    function automatic logic [16:0] exp_pl(input logic [31:0] w);
        logic [31:0] v;
        logic [16:0] r;
        int k;
        v = (w & MASK) ^ 32'h0000_000F;
        r = '0;
        k = 0;
        for (int i = 0; i < 32; i++) begin
            if (MASK[i]) begin
                r[k] = v[i];
                k++;
            end
        end
        return r;
    endfunction

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [11:0] a, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = a; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic t_reset;
        check("R1 sys", 32'(sys_req), 0);
        check("R1 cpu", 32'(cpu_rst), 0);
        check("R1 pl", 32'(pl_rst), 32'h1FFF0);
    endtask

    task automatic t_soft_pulse;
        wr(12'h200, 32'h1);
        check("R2 pulse high", 32'(sys_req), 1);
        @(negedge clk);
        check("R2 pulse low", 32'(sys_req), 0);
        wr(12'h200, 32'hFFFF_FFFE);
        check("R3 no pulse", 32'(sys_req), 0);
        check("R3 pl untouched", 32'(pl_rst), 32'h1FFF0);
        check("R3 cpu untouched", 32'(cpu_rst), 0);
        @(negedge clk);
        wr_en = 1'b1; wr_addr = 12'h200; wr_data = 32'h1;
        @(negedge clk);
        check("R2 b2b first", 32'(sys_req), 1);
        @(negedge clk);
        wr_en = 1'b0;
        check("R2 b2b second", 32'(sys_req), 1);
        @(negedge clk);
        check("R2 b2b end", 32'(sys_req), 0);
    endtask

    task automatic t_cpu;
        wr(12'h244, 32'h1);
        check("R4 cpu 01", 32'(cpu_rst), 32'h1);
        wr(12'h244, 32'hFFFF_FFFE);
        check("R4 cpu 10 upper ignored", 32'(cpu_rst), 32'h2);
        wr(12'h244, 32'h3);
        check("R4 cpu 11", 32'(cpu_rst), 32'h3);
        check("R8 pl unchanged by cpu write", 32'(pl_rst), 32'h1FFF0);
    endtask

    task automatic t_pl_mask;
        wr(12'h240, 32'hFFFF_FFFF);
        check("R5 all ones", 32'(pl_rst), 32'h1FFF0);
        wr(12'h240, ~MASK);
        check("R5 invalid bits only", 32'(pl_rst), 32'h0000F);
        wr(12'h240, 32'h0000_0005);
        check("R6 low four inverted", 32'(pl_rst), 32'h0000A);
    endtask

    task automatic t_pl_map;
        for (int b = 0; b < 32; b++) begin
            wr(12'h240, 32'h1 << b);
            check($sformatf("R7 walk bit %0d", b), 32'(pl_rst), 32'(exp_pl(32'h1 << b)));
        end
        wr(12'h240, 32'h0100_0000);
        check("R7 bit24 to line16", 32'(pl_rst), 32'h1000F);
        wr(12'h240, 32'h0000_0100);
        check("R7 bit8 to line4", 32'(pl_rst), 32'h0001F);
    endtask

    task automatic t_ignore;
        wr(12'h240, 32'h0012_3405);
        check("R7 mixed pattern", 32'(pl_rst), 32'(exp_pl(32'h0012_3405)));
        @(negedge clk);
        wr_en = 1'b0; wr_addr = 12'h240; wr_data = 32'hFFFF_FFFF;
        @(negedge clk);
        check("R8 wr_en low pl", 32'(pl_rst), 32'(exp_pl(32'h0012_3405)));
        wr(12'h204, 32'hFFFF_FFFF);
        check("R8 foreign addr pl", 32'(pl_rst), 32'(exp_pl(32'h0012_3405)));
        check("R8 foreign addr cpu", 32'(cpu_rst), 32'h3);
        check("R8 foreign addr sys", 32'(sys_req), 0);
        wr(12'h000, 32'h0);
        check("R8 addr zero cpu", 32'(cpu_rst), 32'h3);
        wr(12'h248, 32'h0);
        check("R8 addr 248 cpu", 32'(cpu_rst), 32'h3);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        t_reset();
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_soft_pulse();
        t_cpu();
        t_pl_mask();
        t_pl_map();
        t_ignore();
        if (!done) begin
            done = 1;
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 20000);
        if (!done) begin
            done = 1;
            checks++;
            errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end
endmodule